// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable behavioural model of a word-wide synchronous SRAM with flow-through reads and a two-bit linear burst counter. All control inputs are sampled on the rising clock edge. Read data is not held in an output register. It appears on the bidirectional data bus in the same cycle, combinationally from the address held since the last edge. The output enable is asynchronous and only gates the bus drivers.

An access starts when one of two address strobes is sampled low while the chip is selected. The first strobe belongs to the processor and always starts a read. The second belongs to a controller and may start a write in the same cycle. After the access starts, the advance input steps through the other words of the aligned four-word block. A write can be global, covering every byte, or it can cover only the selected bytes. A sleep input freezes the block with its contents kept. The depth is a parameter: `ADDR_W` = 15 gives the 32K-word organisation, and the default is smaller.

Top module: `sram_ft_burst`

## Requirements
- R1: An edge with a strobe low and all three enables active (`en_a_n`=0, `en_b`=1, `en_c_n`=0) captures `addr`. While reading, `dq` then shows the stored word at that address in the cycle after that edge, with no further clock.
- R2: When `strb_cpu_n` and `strb_ctl_n` are both low on one edge with `en_a_n` low, only the processor strobe acts. That edge starts a read and writes nothing, even with write controls active.
- R3: With `en_a_n` high, `strb_cpu_n` is ignored. An edge with `strb_cpu_n` low, `strb_ctl_n` high and `adv_n` high keeps the held address and the ongoing read.
- R4: With a valid address held and no strobe acting, `adv_n` low at an edge adds one to address bits [1:0] modulo 4 and leaves the upper bits unchanged (…11 → …00).
- R5: With no valid address held (after a deselect or a reset) and no strobe acting, `adv_n` and the write controls have no effect: nothing is written and `dq` stays undriven.
- R6: With `wr_all_n` low, an access edge writes all four bytes from `dq`, whatever `wr_byte_n` and `lane_n` are.
- R7: With `wr_all_n` high and `wr_byte_n` low, only the bytes whose `lane_n` bit is low are written. `lane_n[k]` covers `dq[8k+7:8k]`. With both write controls high, the edge is a read.
- R8: `oe_n` high releases `dq` at once, with no clock edge. `oe_n` low drives it at once when a read is ready.
- R9: In the cycle after an address is captured from the deselected state, `dq` is not driven even with `oe_n` low. From the next cycle it is driven.
- R10: With `sleep` high, edges do nothing: no capture, write or advance. `dq` is undriven. Memory contents and the held address survive, and reads resume at that address when `sleep` falls.
- R11: Synchronous active-high `rst` drops the held address, so `dq` is undriven. Memory contents are kept.
- R12: A strobe acting while any enable is inactive deselects the block, and `dq` becomes undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address |
| en_a_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| strb_cpu_n | input | 1 | Processor address strobe, active low, read only |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte write enable, active low |
| lane_n | input | 4 | Byte selects, active low, bit k covers byte k |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep, active high |
| dq | inout | 32 | Bidirectional data bus |

## Verification
The bound assertions check on every cycle several things. Processor-strobe edges and idle edges never write, and a burst step moves only the two low address bits modulo 4. The processor strobe is held off while `en_a_n` is high, a raised `oe_n` or `sleep` always releases the bus, and the bus stays released in the cycle after a capture from deselect. Data values can only be shown by the bench's reference memory and its scenarios. These cover global and byte-masked merges, burst wrap-around reads, and the survival of contents across sleep and reset. They also cover the mid-cycle output enable toggle.

// File: rtl/sram_pkg.sv
package sram_pkg;

    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int DATA_W = BYTE_W * LANES;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [LANES-1:0]  lanes_t;

    // Kind of cycle decided at each rising edge.
    typedef enum logic [2:0] {
        CYC_IDLE,    // sleep, or nothing held and no strobe
        CYC_LOAD_P,  // processor strobe captured an address
        CYC_LOAD_C,  // controller strobe captured an address
        CYC_STEP,    // burst advance
        CYC_HOLD,    // keep address
        CYC_DESEL    // strobe with chip not selected
    } cyc_e;

    // Linear wrap inside a four-word block.
    function automatic logic [1:0] burst_inc(input logic [1:0] cnt);
        return cnt + 2'd1;
    endfunction

    // Global write overrides byte write enable and byte selects.
    function automatic lanes_t write_lanes(input logic all_n,
                                           input logic byte_n,
                                           input lanes_t sel_n);
        if (!all_n)       return '1;
        else if (!byte_n) return ~sel_n;
        else              return '0;
    endfunction

endpackage

// File: rtl/sfb_ctrl.sv
module sfb_ctrl
    import sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    input  logic              en_a_n,
    input  logic              en_b,
    input  logic              en_c_n,
    input  logic              strb_cpu_n,
    input  logic              strb_ctl_n,
    input  logic              adv_n,
    input  logic              wr_all_n,
    input  logic              wr_byte_n,
    input  lanes_t            lane_n,
    output logic              wr_en,
    output lanes_t            wr_mask,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ok,
    output logic              st_valid
);

    logic [ADDR_W-1:0] addr_q, addr_nxt;
    logic              valid_q, read_q, first_q;
    logic              valid_nxt, read_nxt, first_nxt;
    logic              sel_all, cpu_hit, wr_req;
    cyc_e              cyc;

    assign sel_all = !en_a_n && en_b && !en_c_n;
    assign cpu_hit = !strb_cpu_n && !en_a_n;
    assign wr_mask = write_lanes(wr_all_n, wr_byte_n, lane_n);
    assign wr_req  = |wr_mask;

    always_comb begin
        if (sleep)               cyc = CYC_IDLE;
        else if (cpu_hit)        cyc = sel_all ? CYC_LOAD_P : CYC_DESEL;
        else if (!strb_ctl_n)    cyc = sel_all ? CYC_LOAD_C : CYC_DESEL;
        else if (valid_q)        cyc = adv_n ? CYC_HOLD : CYC_STEP;
        else                     cyc = CYC_IDLE;
    end

    always_comb begin
        addr_nxt  = addr_q;
        valid_nxt = valid_q;
        read_nxt  = read_q;
        first_nxt = first_q;
        unique case (cyc)
            CYC_LOAD_P: begin
                addr_nxt  = addr;
                valid_nxt = 1'b1;
                read_nxt  = 1'b1;
                first_nxt = !valid_q;
            end
            CYC_LOAD_C: begin
                addr_nxt  = addr;
                valid_nxt = 1'b1;
                read_nxt  = !wr_req;
                first_nxt = !valid_q;
            end
            CYC_STEP: begin
                addr_nxt  = {addr_q[ADDR_W-1:2], burst_inc(addr_q[1:0])};
                read_nxt  = !wr_req;
                first_nxt = 1'b0;
            end
            CYC_HOLD: begin
                read_nxt  = !wr_req;
                first_nxt = 1'b0;
            end
            CYC_DESEL: begin
                valid_nxt = 1'b0;
                first_nxt = 1'b0;
            end
            default: ;
        endcase
    end

    assign wr_en   = wr_req && (cyc == CYC_LOAD_C || cyc == CYC_STEP || cyc == CYC_HOLD);
    assign wr_addr = addr_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            valid_q <= 1'b0;
            read_q  <= 1'b0;
            first_q <= 1'b0;
        end else begin
            addr_q  <= addr_nxt;
            valid_q <= valid_nxt;
            read_q  <= read_nxt;
            first_q <= first_nxt;
        end
    end

    assign rd_addr  = addr_q;
    assign rd_ok    = valid_q && read_q && !first_q && !sleep;
    assign st_valid = valid_q;

endmodule

// File: rtl/sfb_array.sv
module sfb_array
    import sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              wr_en,
    input  lanes_t            wr_mask,
    input  logic [ADDR_W-1:0] wr_addr,
    input  word_t             wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output word_t             rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    word_t mem [DEPTH];
    word_t old_word, merged;

    assign old_word = mem[wr_addr];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign merged[k*BYTE_W +: BYTE_W] = wr_mask[k] ? wr_data[k*BYTE_W +: BYTE_W]
                                                       : old_word[k*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= merged;
    end

    // Flow-through: no output register.
    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/sram_ft_burst.sv
module sram_ft_burst
    import sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              en_a_n,
    input  logic              en_b,
    input  logic              en_c_n,
    input  logic              strb_cpu_n,
    input  logic              strb_ctl_n,
    input  logic              adv_n,
    input  logic              wr_all_n,
    input  logic              wr_byte_n,
    input  logic [3:0]        lane_n,
    input  logic              oe_n,
    input  logic              sleep,
    inout  wire  [31:0]       dq
);

    logic              wr_en;
    lanes_t            wr_mask;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic              rd_ok, st_valid, dq_drive;
    word_t             rdata;

    sfb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .sleep     (sleep),
        .addr      (addr),
        .en_a_n    (en_a_n),
        .en_b      (en_b),
        .en_c_n    (en_c_n),
        .strb_cpu_n(strb_cpu_n),
        .strb_ctl_n(strb_ctl_n),
        .adv_n     (adv_n),
        .wr_all_n  (wr_all_n),
        .wr_byte_n (wr_byte_n),
        .lane_n    (lane_n),
        .wr_en     (wr_en),
        .wr_mask   (wr_mask),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr),
        .rd_ok     (rd_ok),
        .st_valid  (st_valid)
    );

    sfb_array #(.ADDR_W(ADDR_W)) u_array (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_mask(wr_mask),
        .wr_addr(wr_addr),
        .wr_data(dq),
        .rd_addr(rd_addr),
        .rd_data(rdata)
    );

    // Output enable acts without a clock.
    assign dq_drive = rd_ok && !oe_n;
    assign dq       = dq_drive ? rdata : 'z;

endmodule

// File: rtl/sfb_chk.sv
module sfb_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              en_a_n,
    input logic              en_b,
    input logic              en_c_n,
    input logic              strb_cpu_n,
    input logic              strb_ctl_n,
    input logic              adv_n,
    input logic              oe_n,
    input logic              sleep,
    input logic              wr_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              st_valid,
    input logic              dq_drive
);

    logic no_strobe;
    assign no_strobe = (strb_cpu_n || en_a_n) && strb_ctl_n;

    AST_CPU_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !strb_cpu_n && !en_a_n) |-> !wr_en);  // R2

    AST_CPU_GATED: assert property (@(posedge clk) disable iff (rst)
        (!sleep && st_valid && en_a_n && strb_ctl_n && adv_n)
        |=> (st_valid && $stable(rd_addr)));  // R3

    AST_BURST_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!sleep && st_valid && no_strobe && !adv_n)
        |=> ((rd_addr[1:0] == $past(rd_addr[1:0]) + 2'd1)
             && (rd_addr[ADDR_W-1:2] == $past(rd_addr[ADDR_W-1:2]))));  // R4

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !st_valid && no_strobe) |-> !wr_en);  // R5

    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dq_drive);  // R8

    AST_FIRST_MASK: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !st_valid && !strb_cpu_n && !en_a_n && en_b && !en_c_n)
        |=> !dq_drive);  // R9

    AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (rst)
        sleep |=> ($stable(rd_addr) && $stable(st_valid)));  // R10

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (rst)
        sleep |-> (!wr_en && !dq_drive));  // R10

    AST_DESELECT: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !strb_ctl_n && (strb_cpu_n || en_a_n) && (en_a_n || !en_b || en_c_n))
        |=> !st_valid);  // R12

endmodule

bind sram_ft_burst sfb_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en_a_n    (en_a_n),
    .en_b      (en_b),
    .en_c_n    (en_c_n),
    .strb_cpu_n(strb_cpu_n),
    .strb_ctl_n(strb_ctl_n),
    .adv_n     (adv_n),
    .oe_n      (oe_n),
    .sleep     (sleep),
    .wr_en     (wr_en),
    .rd_addr   (rd_addr),
    .st_valid  (st_valid),
    .dq_drive  (dq_drive)
);

// File: tb/test_sram_ft_burst.sv
`timescale 1ns/1ps
module test_sram_ft_burst;

    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic          en_a_n, en_b, en_c_n;
    logic          strb_cpu_n, strb_ctl_n, adv_n;
    logic          wr_all_n, wr_byte_n;
    logic [3:0]    lane_n;
    logic          oe_n, sleep;
    logic          tb_drv;
    logic [31:0]   tb_dq;
    wire  [31:0]   dq;

    assign dq = tb_drv ? tb_dq : 'z;

    always #10 clk = ~clk;  // 50 MHz

    sram_ft_burst #(.ADDR_W(AW)) i_sram_ft_burst (
        .clk(clk), .rst(rst), .addr(addr),
        .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n),
        .oe_n(oe_n), .sleep(sleep), .dq(dq)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    running = 0;

    // Reference model state
    logic [31:0] ref_mem [int];
    int          m_addr = 0;
    bit          m_valid = 0, m_read = 0, m_first = 0;

    function automatic logic [31:0] ref_word(input int a);
        if (ref_mem.exists(a)) return ref_mem[a];
        return 32'hx;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_valid = 0; m_read = 0; m_first = 0;
        end else if (!sleep) begin
            bit sel, cpu, doload, wr;
            logic [3:0] lanes;
            int tgt;
            sel   = !en_a_n && en_b && !en_c_n;
            cpu   = !strb_cpu_n && !en_a_n;
            lanes = !wr_all_n ? 4'hF : (!wr_byte_n ? ~lane_n : 4'h0);
            wr    = 0;
            doload = 0;
            tgt   = m_addr;
            if (cpu || !strb_ctl_n) begin
                if (sel) begin
                    doload = 1;
                    tgt = int'(addr);
                    wr  = !cpu && (lanes != 0);
                end else begin
                    m_valid = 0; m_first = 0;
                end
            end else if (m_valid) begin
                if (!adv_n) tgt = (m_addr & ~3) | ((m_addr + 1) & 3);
                wr = (lanes != 0);
            end
            if (doload) begin
                m_first = !m_valid;
                m_valid = 1;
                m_addr  = tgt;
                m_read  = !wr;
            end else if (m_valid && !(cpu || !strb_ctl_n)) begin
                m_first = 0;
                m_addr  = tgt;
                m_read  = !wr;
            end
            if (wr) begin
                logic [31:0] w;
                w = ref_word(tgt);
                for (int k = 0; k < 4; k++)
                    if (lanes[k]) w[8*k +: 8] = tb_dq[8*k +: 8];
                ref_mem[tgt] = w;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the reference model.
    always @(negedge clk) begin
        if (running && !rst) begin
            logic [31:0] w;
            bit exp_drive;
            w = ref_word(m_addr);
            exp_drive = m_valid && m_read && !m_first && !sleep && !oe_n;
            if (exp_drive && !$isunknown(w))
                chk(dq === w, cur_req, dq, w, "cycle data");
            else if (!exp_drive && !tb_drv && !$isunknown(w) && w != 0)
                chk(dq !== w, cur_req, dq, w, "cycle bus released");
        end
    end

    task automatic tick();
        @(negedge clk);
        #2;
    endtask

    task automatic idle();
        addr = '0; en_a_n = 0; en_b = 1; en_c_n = 0;
        strb_cpu_n = 1; strb_ctl_n = 1; adv_n = 1;
        wr_all_n = 1; wr_byte_n = 1; lane_n = 4'hF;
        oe_n = 0; sleep = 0; tb_drv = 0; tb_dq = '0;
    endtask

    task automatic expect_data(input string req, input logic [31:0] exp);
        chk(dq === exp, req, dq, exp, "data");
    endtask

    task automatic expect_off(input string req, input logic [31:0] word);
        chk(dq !== word, req, dq, word, "bus should be released");
    endtask

    localparam logic [31:0] W0 = 32'hA0A0_0100;
    localparam logic [31:0] W1 = 32'hB1B1_0101;
    localparam logic [31:0] W2 = 32'hC2C2_0102;
    localparam logic [31:0] W3 = 32'hD3D3_0103;
    localparam logic [31:0] W0B = 32'h5A5A_0100;
    localparam logic [31:0] W1M = {W1[31:24], 8'h22, W1[15:8], 8'h44};

    initial begin
        idle();
        rst = 1;
        tick(); tick();
        rst = 0;
        running = 1;

        // R11: after reset nothing is driven even with oe_n low
        cur_req = "R11";
        tick();
        chk(dq !== 32'hA0A0_0100, "R11", dq, 32'hA0A0_0100, "reset state released");

        // R6: global write via controller strobe, then burst writes
        cur_req = "R6";
        oe_n = 1; tb_drv = 1;
        strb_ctl_n = 0; addr = 10'h100; wr_all_n = 0; tb_dq = W0;
        tick();
        strb_ctl_n = 1; adv_n = 0; tb_dq = W1; tick();
        tb_dq = W2; tick();
        tb_dq = W3; tick();
        // R6: wrap to 0x100, global write with byte controls inactive
        wr_byte_n = 1; lane_n = 4'hF; tb_dq = W0B; tick();
        idle();

        // R1: processor strobe read of 0x102 (already selected, not first)
        cur_req = "R1";
        strb_cpu_n = 0; addr = 10'h102; tick();
        strb_cpu_n = 1;
        expect_data("R1", W2);
        // R4: burst steps and wrap within block
        cur_req = "R4";
        adv_n = 0; tick();
        expect_data("R4", W3);
        tick();
        expect_data("R4", W0B);  // R4 wrap 11 -> 00
        tick();
        expect_data("R4", W1);
        adv_n = 1;

        // R7: byte write at held address 0x101, lanes 0 and 2
        cur_req = "R7";
        oe_n = 1; tb_drv = 1; wr_byte_n = 0; lane_n = 4'b1010; tb_dq = 32'h1122_3344;
        tick();
        idle();
        tick();
        expect_data("R7", W1M);

        // R2: both strobes low with global write: read only
        cur_req = "R2";
        strb_cpu_n = 0; strb_ctl_n = 0; addr = 10'h103; wr_all_n = 0;
        tick();
        idle();
        expect_data("R2", W3);

        // R3: processor strobe with en_a_n high is ignored
        cur_req = "R3";
        en_a_n = 1; strb_cpu_n = 0; addr = 10'h100; tick();
        idle();
        expect_data("R3", W3);

        // R12: controller strobe with en_b low deselects
        cur_req = "R12";
        en_b = 0; strb_ctl_n = 0; addr = 10'h100; tick();
        idle();
        expect_off("R12", W3);

        // R5: advance and write with nothing held have no effect
        cur_req = "R5";
        adv_n = 0; wr_all_n = 0; tb_drv = 1; oe_n = 1; tb_dq = 32'h0; tick();
        idle();
        tick();
        expect_off("R5", W3);

        // R9: capture from deselect masks the first cycle
        cur_req = "R9";
        strb_cpu_n = 0; addr = 10'h103; tick();
        strb_cpu_n = 1;
        expect_off("R9", W3);
        tick();
        expect_data("R9", W3);  // R5 also: 0x103 not overwritten

        // R8: asynchronous output enable
        cur_req = "R8";
        #3 oe_n = 1; #1;
        expect_off("R8", W3);
        oe_n = 0; #1;
        expect_data("R8", W3);
        tick();

        // R10: sleep blocks capture and write
        cur_req = "R10";
        sleep = 1; strb_ctl_n = 0; addr = 10'h102; wr_all_n = 0;
        oe_n = 1; tb_drv = 1; tb_dq = 32'h0;
        tick();
        tb_drv = 0; oe_n = 0; strb_ctl_n = 1; wr_all_n = 1; adv_n = 0;
        tick();
        expect_off("R10", W3);
        idle();
        tick();
        expect_data("R10", W3);
        strb_cpu_n = 0; addr = 10'h102; tick();
        strb_cpu_n = 1;
        expect_data("R10", W2);

        // R11: mid-run reset releases bus, keeps memory
        cur_req = "R11";
        rst = 1; tick();
        rst = 0; tick();
        expect_off("R11", W2);
        strb_cpu_n = 0; addr = 10'h101; tick();
        strb_cpu_n = 1; tick();
        expect_data("R11", W1M);
        tick();

        running = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule